// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block drives a single D-PHY data lane through one complete high-speed burst, one unit interval per clock. Between bursts it parks the lane in the single-ended stop state. On a start request it walks the single-ended pair through the two low-power entry states and then switches to high speed. In high speed it sends a run of zeros, then the sync byte. It then serializes the payload bytes it pulls over a valid/ready stream, least significant bit first. It ends with a trail that holds the inverse of the final data bit, and then returns to the stop state.

The LP01 entry time, the LP00 entry time, the zero preamble and the trail are each set by an 8-bit count of bit clocks. A count of zero behaves as one. The four counts are captured when a burst begins, so they can be rewritten freely while a burst runs. The lane has no way to pause once it is in high speed. A byte must therefore be offered when the block asks for it; if none is offered, the payload closes at that byte boundary.

Top module: `dphy_burst_seq`

## Requirements
- R1: After reset, and whenever no burst is active, `lp_state` is 2'b11, `hs_en` is 0, `hs_bit` is 0 and `pay_ready` is 0.
- R2: A start request seen in the stop state is followed on the wire by exactly one cycle of 2'b11. Then `lp_state` is 2'b01 for max(`cfg_lp01_len`,1) cycles and 2'b00 for max(`cfg_lp00_len`,1) cycles, with `hs_en` low throughout.
- R3: After the LP00 phase, `hs_en` is 1 and `hs_bit` is 0 for max(`cfg_zero_len`,1) cycles. `lp_state` is 2'b00 in every cycle that `hs_en` is 1.
- R4: The zero preamble is followed by eight cycles carrying 0,0,0,1,1,1,0,1 on `hs_bit`, which is the byte 0xB8 sent least significant bit first.
- R5: Each accepted payload byte appears on `hs_bit` over eight consecutive cycles, bit 0 first. Bytes follow one another with no gap, starting right after the sync byte.
- R6: `pay_ready` is 1 for exactly one cycle per byte slot and only during the payload phase. A byte is taken on a rising edge where `pay_ready` and `pay_valid` are both 1.
- R7: A byte accepted with `pay_last` = 1 is the final payload byte of the burst.
- R8: After the final payload bit, `hs_bit` holds the inverse of that bit for max(`cfg_trail_len`,1) cycles. After that, `hs_en` falls and `lp_state` returns to 2'b11 in the same cycle.
- R9: If `pay_valid` is 0 at a byte slot, the payload ends there. The wire is then identical to the case where the previous byte carried `pay_last`.
- R10: The four length inputs are captured on the edge that accepts the start request. Changes to them during a burst do not affect that burst.
- R11: A start request while a burst is in progress is ignored. It neither restarts nor extends the burst, and the lane stays in 2'b11 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one unit interval per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a burst, acted on only in the stop state |
| cfg_lp01_len | input | 8 | LP01 entry length in bit clocks |
| cfg_lp00_len | input | 8 | LP00 entry length in bit clocks |
| cfg_zero_len | input | 8 | High-speed zero preamble length in bit clocks |
| cfg_trail_len | input | 8 | Trail length in bit clocks |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte is offered |
| pay_last | input | 1 | Offered byte is the final one |
| pay_ready | output | 1 | Block takes a byte on this edge if valid |
| lp_state | output | 2 | Single-ended line state, bit 1 on the positive wire |
| hs_en | output | 1 | High-speed driver enable |
| hs_bit | output | 1 | Serial high-speed bit |

## Verification
The hardest case to reach is a byte slot with nothing offered. The block ends the payload on its own there. It must emit a trail that is bit-for-bit the same as the one produced by an explicit last flag, and it must leave `pay_ready` high for that one extra slot. The stimulus reaches this case by running out of queued bytes without ever raising `pay_last`. Random bursts mix that ending with flagged endings, zero-valued lengths, length inputs rewritten mid-burst, and start pulses during the high-speed phases, and each burst's whole wire trace is compared cycle by cycle.

// File: rtl/dphy_lane_pkg.sv
package dphy_lane_pkg;
  typedef enum logic [2:0] {
    SEQ_STOP,
    SEQ_LP01,
    SEQ_LP00,
    SEQ_ZERO,
    SEQ_SYNC,
    SEQ_LOAD,
    SEQ_SHIFT,
    SEQ_TRAIL
  } seq_state_t;

  localparam logic [1:0] LINE_STOP = 2'b11;
  localparam logic [1:0] LINE_REQ  = 2'b01;
  localparam logic [1:0] LINE_BRG  = 2'b00;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done = (cnt_q == '0);

  // the count parks at zero until reloaded
  assert_timer_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done);
endmodule

// File: rtl/bit_serializer.sv
module bit_serializer #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic              step,
  output logic              cur_bit,
  output logic              at_end
);
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_byte;
      idx_q <= load_idx;
    end else if (step) begin
      idx_q <= at_end ? '0 : idx_q + IDX_W'(1);
    end
  end

  assign cur_bit = sh_q[idx_q];
  assign at_end  = (idx_q == IDX_W'(BYTE_W - 1));

  // the bit position only moves on a step or a load
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(idx_q));
endmodule

// File: rtl/dphy_burst_seq.sv
module dphy_burst_seq
  import dphy_lane_pkg::*;
#(
  parameter int              LEN_W     = 8,
  parameter int              BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [LEN_W-1:0]  cfg_lp01_len,
  input  logic [LEN_W-1:0]  cfg_lp00_len,
  input  logic [LEN_W-1:0]  cfg_zero_len,
  input  logic [LEN_W-1:0]  cfg_trail_len,
  input  logic [BYTE_W-1:0] pay_data,
  input  logic              pay_valid,
  input  logic              pay_last,
  output logic              pay_ready,
  output logic [1:0]        lp_state,
  output logic              hs_en,
  output logic              hs_bit
);
  localparam int IDX_W = $clog2(BYTE_W);

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction

  seq_state_t st_q, st_n;
  logic [LEN_W-1:0] lp00_q, zero_q, trail_q;
  logic [LEN_W-1:0] trail_eff;
  logic             last_q, last_n;
  logic             tbit_q, tbit_n;
  logic [1:0]       lp_q, lp_n;
  logic             en_q, en_n, bit_q, bit_n;

  logic             tm_load, tm_done;
  logic [LEN_W-1:0] tm_val;
  logic             ser_load, ser_step, ser_bit, ser_end;
  logic [BYTE_W-1:0] ser_byte;
  logic [IDX_W-1:0]  ser_idx;

  phase_timer #(.CNT_W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  bit_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .load_byte(ser_byte),
    .load_idx(ser_idx), .step(ser_step), .cur_bit(ser_bit), .at_end(ser_end)
  );

  assign trail_eff = eff_len(trail_q);

  always_comb begin
    st_n     = st_q;
    tm_load  = 1'b0;
    tm_val   = '0;
    ser_load = 1'b0;
    ser_step = 1'b0;
    ser_byte = SYNC_WORD;
    ser_idx  = '0;
    last_n   = last_q;
    tbit_n   = tbit_q;
    lp_n     = LINE_BRG;
    en_n     = 1'b1;
    bit_n    = 1'b0;
    unique case (st_q)
      SEQ_STOP: begin
        lp_n = LINE_STOP;
        en_n = 1'b0;
        if (start_req) begin
          st_n    = SEQ_LP01;
          tm_load = 1'b1;
          tm_val  = eff_len(cfg_lp01_len) - LEN_W'(1);
        end
      end
      SEQ_LP01: begin
        lp_n = LINE_REQ;
        en_n = 1'b0;
        if (tm_done) begin
          st_n    = SEQ_LP00;
          tm_load = 1'b1;
          tm_val  = eff_len(lp00_q) - LEN_W'(1);
        end
      end
      SEQ_LP00: begin
        en_n = 1'b0;
        if (tm_done) begin
          st_n    = SEQ_ZERO;
          tm_load = 1'b1;
          tm_val  = eff_len(zero_q) - LEN_W'(1);
        end
      end
      SEQ_ZERO: begin
        if (tm_done) begin
          st_n     = SEQ_SYNC;
          ser_load = 1'b1;
        end
      end
      SEQ_SYNC: begin
        bit_n    = ser_bit;
        ser_step = 1'b1;
        if (ser_end) st_n = SEQ_LOAD;
      end
      SEQ_LOAD: begin
        if (pay_valid) begin
          bit_n    = pay_data[0];
          ser_load = 1'b1;
          ser_byte = pay_data;
          ser_idx  = IDX_W'(1);
          last_n   = pay_last;
          st_n     = SEQ_SHIFT;
        end else begin
          // no byte at the slot: this cycle is the first trail cycle
          bit_n  = ~bit_q;
          tbit_n = ~bit_q;
          if (trail_eff == LEN_W'(1)) begin
            st_n = SEQ_STOP;
          end else begin
            st_n    = SEQ_TRAIL;
            tm_load = 1'b1;
            tm_val  = trail_eff - LEN_W'(2);
          end
        end
      end
      SEQ_SHIFT: begin
        bit_n    = ser_bit;
        ser_step = 1'b1;
        if (ser_end) begin
          if (last_q) begin
            st_n    = SEQ_TRAIL;
            tm_load = 1'b1;
            tm_val  = trail_eff - LEN_W'(1);
            tbit_n  = ~ser_bit;
          end else begin
            st_n = SEQ_LOAD;
          end
        end
      end
      SEQ_TRAIL: begin
        bit_n = tbit_q;
        if (tm_done) st_n = SEQ_STOP;
      end
      default: begin
        st_n = SEQ_STOP;
        lp_n = LINE_STOP;
        en_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEQ_STOP;
      lp00_q  <= '0;
      zero_q  <= '0;
      trail_q <= '0;
      last_q  <= 1'b0;
      tbit_q  <= 1'b0;
      lp_q    <= LINE_STOP;
      en_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      last_q <= last_n;
      tbit_q <= tbit_n;
      lp_q   <= lp_n;
      en_q   <= en_n;
      bit_q  <= bit_n;
      if (st_q == SEQ_STOP && start_req) begin
        lp00_q  <= cfg_lp00_len;
        zero_q  <= cfg_zero_len;
        trail_q <= cfg_trail_len;
      end
    end
  end

  assign pay_ready = (st_q == SEQ_LOAD);
  assign lp_state  = lp_q;
  assign hs_en     = en_q;
  assign hs_bit    = bit_q;

  // leaving the stop state must go through LP01 first
  assert_stop_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (lp_state == LINE_STOP) |=> (lp_state == LINE_STOP || lp_state == LINE_REQ));

  // LP01 is followed by LP01 or LP00, never by high speed directly
  assert_req_next_R2: assert property (@(posedge clk) disable iff (rst)
    (lp_state == LINE_REQ) |=> (!hs_en && (lp_state == LINE_REQ || lp_state == LINE_BRG)));

  // the single-ended pair sits at 00 while high speed is driven
  assert_hs_pair_low_R3: assert property (@(posedge clk) disable iff (rst)
    hs_en |-> (lp_state == LINE_BRG));

  // bytes are asked for only inside the high-speed burst
  assert_ready_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> hs_en);

  // the end of high speed lands directly in the stop state
  assert_hs_exit_stop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_en) |-> (lp_state == LINE_STOP));

  // a high-speed zero run is never followed by a return to LP01
  assert_no_reentry_R11: assert property (@(posedge clk) disable iff (rst)
    hs_en |=> (lp_state != LINE_REQ));
endmodule

// File: tb/test_dphy_burst_seq.sv
`timescale 1ns/1ps
module test_dphy_burst_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_req;
  logic [7:0] cfg_lp01_len, cfg_lp00_len, cfg_zero_len, cfg_trail_len;
  logic [7:0] pay_data;
  logic       pay_valid, pay_last;
  logic       pay_ready;
  logic [1:0] lp_state;
  logic       hs_en, hs_bit;

  always #2 clk = ~clk;

  dphy_burst_seq i_dphy_burst_seq (
    .clk(clk), .rst(rst), .start_req(start_req),
    .cfg_lp01_len(cfg_lp01_len), .cfg_lp00_len(cfg_lp00_len),
    .cfg_zero_len(cfg_zero_len), .cfg_trail_len(cfg_trail_len),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
    .pay_ready(pay_ready), .lp_state(lp_state), .hs_en(hs_en), .hs_bit(hs_bit)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] payload [64];
  logic [1:0] exp_lp  [2048];
  bit         exp_en  [2048];
  bit         exp_bit [2048];
  string      exp_tag [2048];
  int         exp_n;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic add(input logic [1:0] lp, input bit en, input bit b, input string tag);
    exp_lp[exp_n]  = lp;
    exp_en[exp_n]  = en;
    exp_bit[exp_n] = b;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  // expected wire trace, one entry per cycle, starting at the start edge
  task automatic build(input int l1, input int l0, input int z, input int t, input int n);
    bit lastb;
    exp_n = 0;
    add(2'b11, 0, 0, "R2");
    for (int i = 0; i < eff(l1); i++) add(2'b01, 0, 0, "R2");
    for (int i = 0; i < eff(l0); i++) add(2'b00, 0, 0, "R2");
    for (int i = 0; i < eff(z); i++)  add(2'b00, 1, 0, "R3");
    for (int i = 0; i < 8; i++) begin
      lastb = (8'hB8 >> i) & 8'h01;
      add(2'b00, 1, lastb, "R4");
    end
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) begin
        lastb = payload[j][i];
        add(2'b00, 1, lastb, "R5");
      end
    for (int i = 0; i < eff(t); i++) add(2'b00, 1, ~lastb, "R8");
    for (int i = 0; i < 3; i++) add(2'b11, 0, 0, "R8");
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (lp_state !== 2'b11 || hs_en !== 1'b0 || hs_bit !== 1'b0 || pay_ready !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: lp=%b en=%b bit=%b rdy=%b expected lp=11 en=0 bit=0 rdy=0",
               tag, lp_state, hs_en, hs_bit, pay_ready);
    end
  endtask

  task automatic run_burst(input int l1, input int l0, input int z, input int t, input int n,
                           input bit use_last, input bit mid_cfg, input bit mid_start);
    int  bidx, rcount, takes, mid;
    bit  took;
    string extra;
    @(negedge clk);
    cfg_lp01_len  = 8'(l1);
    cfg_lp00_len  = 8'(l0);
    cfg_zero_len  = 8'(z);
    cfg_trail_len = 8'(t);
    build(l1, l0, z, t, n);
    extra = mid_cfg ? " R10" : (mid_start ? " R11" : "");
    bidx = 0; rcount = 0; takes = 0; took = 0;
    pay_valid = 1'b1;
    pay_data  = payload[0];
    pay_last  = use_last && (n == 1);
    start_req = 1'b1;
    mid = exp_n / 2;
    for (int k = 0; k < exp_n; k++) begin
      @(negedge clk);
      if (k == 0) start_req = 1'b0;
      checks++;
      if (lp_state !== exp_lp[k] || hs_en !== exp_en[k] || hs_bit !== exp_bit[k]) begin
        errors++;
        $display("FAIL %s%s cycle %0d: lp=%b en=%b bit=%b expected lp=%b en=%b bit=%b",
                 exp_tag[k], extra, k, lp_state, hs_en, hs_bit, exp_lp[k], exp_en[k], exp_bit[k]);
      end
      if (mid_cfg && k == 2) begin
        cfg_lp01_len  = 8'($urandom);
        cfg_lp00_len  = 8'($urandom);
        cfg_zero_len  = 8'($urandom);
        cfg_trail_len = 8'($urandom);
      end
      if (mid_start) start_req = (k == mid);
      if (took) begin
        takes++;
        bidx++;
        pay_valid = (bidx < n);
        pay_data  = (bidx < n) ? payload[bidx] : 8'h00;
        pay_last  = use_last && (bidx == n - 1);
      end
      if (pay_ready) rcount++;
      took = pay_ready && pay_valid;
    end
    pay_valid = 1'b0;
    pay_last  = 1'b0;
    start_req = 1'b0;
    checks++;
    if (rcount != n + (use_last ? 0 : 1)) begin
      errors++;
      $display("FAIL R6 ready cycles: got %0d expected %0d", rcount, n + (use_last ? 0 : 1));
    end
    checks++;
    if (takes != n) begin
      errors++;
      $display("FAIL %s bytes taken: got %0d expected %0d", use_last ? "R7" : "R9", takes, n);
    end
    repeat (3) begin
      @(negedge clk);
      check_idle(mid_start ? "R11" : "R1");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired (R1 burst never completed)");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start_req = 1'b0;
    cfg_lp01_len = '0; cfg_lp00_len = '0; cfg_zero_len = '0; cfg_trail_len = '0;
    pay_data = '0; pay_valid = 1'b0; pay_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1");

    // R2 R3 R8: every length zero behaves as one
    payload[0] = 8'h24;
    run_burst(0, 0, 0, 0, 1, 1, 0, 0);
    // R5 R7: bit order of known bytes, flagged end
    payload[0] = 8'h24; payload[1] = 8'h80; payload[2] = 8'h07;
    run_burst(3, 2, 5, 4, 3, 1, 0, 0);
    // R8: trail after a final bit of 0 and of 1
    payload[0] = 8'hFF;
    run_burst(1, 1, 2, 3, 1, 1, 0, 0);
    // R9: stream runs dry with no last flag
    payload[0] = 8'hB5; payload[1] = 8'hC1;
    run_burst(2, 2, 3, 3, 2, 0, 0, 0);
    // R9 with a one-cycle trail
    payload[0] = 8'h01;
    run_burst(1, 1, 1, 1, 1, 0, 0, 0);
    // R10: lengths rewritten during the burst
    payload[0] = 8'h5A; payload[1] = 8'h3C;
    run_burst(4, 3, 6, 5, 2, 1, 1, 0);
    // R11: start pulse in the middle of high speed
    payload[0] = 8'h96; payload[1] = 8'h69; payload[2] = 8'hF0;
    run_burst(2, 2, 4, 2, 3, 1, 0, 1);
    // long phase counts
    payload[0] = 8'hA5;
    run_burst(255, 1, 255, 255, 1, 1, 0, 0);

    for (int r = 0; r < 30; r++) begin
      int n;
      n = 1 + ($urandom % 6);
      for (int j = 0; j < n; j++) payload[j] = 8'($urandom);
      run_burst($urandom % 8, $urandom % 8, $urandom % 10, $urandom % 8, n,
                1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule